// File: doc/BRIEF.md
# Banked Nibble Register File

This block holds the general registers of a nibble-oriented processor: four banks, each of eight 4-bit registers named X, A, B, C, D, E, H and L. The execution unit reads and writes a single register of the active bank, or reads and writes a register pair as one byte. It can also reach a "primed" copy of each pair that lives in the partner bank, which is the active bank with bit 0 flipped. The active bank comes from a 2-bit bank select register gated by a one-bit enable flag. The same cells are also visible to the data-memory path at the lowest 32 addresses of memory bank 0, so a memory store there changes a register.

The enable flag is managed around interrupts by a small state machine with a LIFO save stack. The states are ST_EMPTY (nothing saved), ST_NESTED (at least one saved entry, room for more) and ST_FULL (every slot used). The transitions are: ST_EMPTY to ST_NESTED on entry; ST_NESTED to ST_NESTED on entry with room left or on return with more than one entry; ST_NESTED to ST_FULL on the entry that uses the last slot; ST_NESTED to ST_EMPTY on the return that pops the last entry; ST_FULL to ST_NESTED on return; and ST_FULL to ST_FULL on entry, where the save is dropped. A return in ST_EMPTY keeps the state unchanged.

Top module: `nreg_bank_file`

## Requirements
- R1: After reset every register cell reads 0, the enable flag `bank_en` is 0 and the bank select register is 0, so `active_bank` is 0.
- R2: `active_bank` equals the bank select value when `bank_en` is 1 and equals 0 when `bank_en` is 0. All register accesses that are not primed use `active_bank`.
- R3: A write to the bank select register (`sel_we`) or to the enable flag (`flag_we`) shows on the outputs one cycle later.
- R4: A single-register read or write uses a 3-bit index. The offsets are X=0, A=1, B=2, C=3, D=4, E=5, H=6 and L=7. A nibble write stores `reg_wdata[3:0]` at the clock edge. Reads are combinational.
- R5: Pair code 0 selects XA, 1 selects BC, 2 selects DE and 3 selects HL. A pair occupies offsets 2*code (high nibble, the first-named register) and 2*code+1 (low nibble). A wide write stores `reg_wdata[7:4]` high and `reg_wdata[3:0]` low.
- R6: With the primed select set, a pair read or wide write uses bank `active_bank` XOR 1.
- R7: Memory address bits 4:3 give the bank and bits 2:0 give the offset. `mem_rdata` returns that cell combinationally, and `mem_we` writes it at the clock edge.
- R8: When a register write and a memory write hit the same cell in one cycle, the register write is the one stored.
- R9: An interrupt entry pushes the current flag and sets `bank_en` to the entry value (default 1) on the next cycle. It overrides a flag write or a return in the same cycle.
- R10: A return pops the most recently saved flag into `bank_en`, so nested entries unwind in LIFO order. A return overrides a flag write in the same cycle.
- R11: When the stack holds 8 saved flags, a further entry still sets the flag, but its save is dropped. The following returns restore the 8 stored values.
- R12: A return while nothing is saved leaves `bank_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Load the bank select register |
| sel_wdata | input | 2 | New bank select value |
| flag_we | input | 1 | Load the enable flag |
| flag_wdata | input | 1 | New enable flag value |
| irq_enter | input | 1 | Interrupt entry event |
| irq_return | input | 1 | Return-from-interrupt event |
| nib_ridx | input | 3 | Register index for nibble read |
| nib_rdata | output | 4 | Nibble read data from the active bank |
| pair_rsel | input | 2 | Pair code for byte read |
| pair_ralt | input | 1 | Byte read uses the primed bank |
| pair_rdata | output | 8 | Byte read data, high nibble first-named |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1: pair write, 0: nibble write |
| reg_widx | input | 3 | Register index for nibble write |
| reg_wpair | input | 2 | Pair code for pair write |
| reg_walt | input | 1 | Pair write uses the primed bank |
| reg_wdata | input | 8 | Write data |
| mem_we | input | 1 | Memory-path write strobe |
| mem_addr | input | 5 | Memory-path address of the cell |
| mem_wdata | input | 4 | Memory-path write data |
| mem_rdata | output | 4 | Memory-path read data |
| bank_en | output | 1 | Current enable flag |
| active_bank | output | 2 | Bank in effect for register accesses |

## Verification
A flag that gets out of step with the save stack shows on `bank_en` in the cycle after the return that should have restored it. It also moves `active_bank`, and through that changes every nibble and pair read in the same cycle. A wrong bank or offset computation puts data in the wrong cell. This is caught the first time that cell is read back through the other path: the memory alias checks register writes, and the register path checks memory writes. Overflow handling only shows after the ninth nested entry, when the following returns unwind.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
    localparam int NRF_NIB_W   = 4;
    localparam int NRF_REGS    = 8;
    localparam int NRF_BANKS   = 4;
    localparam int NRF_DEPTH   = 8;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } nest_state_t;

    typedef enum logic [1:0] {
        PR_XA = 2'd0,
        PR_BC = 2'd1,
        PR_DE = 2'd2,
        PR_HL = 2'd3
    } pair_code_t;
endpackage

// File: rtl/nrf_bank_ctrl.sv
module nrf_bank_ctrl
    import nrf_pkg::*;
#(
    parameter int   STK_DEPTH  = NRF_DEPTH,
    parameter logic ENTRY_FLAG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    input  logic       flag_we,
    input  logic       flag_wdata,
    input  logic       irq_enter,
    input  logic       irq_return,
    output logic       flag_q,
    output logic [1:0] sel_q,
    output logic [1:0] bank_o
);
    localparam int PTR_W = $clog2(STK_DEPTH + 1);
    localparam int IDX_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(STK_DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

    nest_state_t          state_q, state_d;
    logic [PTR_W-1:0]     ptr_q;
    logic [STK_DEPTH-1:0] stk_q;
    logic                 push, pop;
    logic [PTR_W-1:0]     top_ptr;
    logic [IDX_W-1:0]     wr_idx, rd_idx;

    assign top_ptr = ptr_q - ONE;
    assign wr_idx  = ptr_q[IDX_W-1:0];
    assign rd_idx  = top_ptr[IDX_W-1:0];

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (irq_enter) state_d = (STK_DEPTH == 1) ? ST_FULL : ST_NESTED;
            end
            ST_NESTED: begin
                if (irq_enter) begin
                    if (ptr_q == LAST) state_d = ST_FULL;
                end else if (irq_return) begin
                    if (ptr_q == ONE) state_d = ST_EMPTY;
                end
            end
            ST_FULL: begin
                if (!irq_enter && irq_return)
                    state_d = (STK_DEPTH == 1) ? ST_EMPTY : ST_NESTED;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        unique case (state_q)
            ST_EMPTY:  push = irq_enter;
            ST_NESTED: begin
                push = irq_enter;
                pop  = !irq_enter && irq_return;
            end
            ST_FULL:   pop  = !irq_enter && irq_return;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            stk_q  <= '0;
            flag_q <= 1'b0;
            sel_q  <= 2'd0;
        end else begin
            if (sel_we) sel_q <= sel_wdata;
            if (push) begin
                stk_q[wr_idx] <= flag_q;
                ptr_q         <= ptr_q + ONE;
            end else if (pop) begin
                ptr_q <= top_ptr;
            end
            if (irq_enter)    flag_q <= ENTRY_FLAG;
            else if (pop)     flag_q <= stk_q[rd_idx];
            else if (flag_we) flag_q <= flag_wdata;
        end
    end

    assign bank_o = sel_q & {2{flag_q}};

    p_sel_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_q == $past(sel_wdata)));

    p_entry_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> (flag_q == ENTRY_FLAG));

    p_empty_return_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && irq_return && !irq_enter && !flag_we) |=> $stable(flag_q));

    p_full_keeps_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && irq_enter) |=> (state_q == ST_FULL && $stable(ptr_q)));

    p_ptr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q <= PTR_W'(STK_DEPTH)));
endmodule

// File: rtl/nrf_cell_array.sv
module nrf_cell_array
    import nrf_pkg::*;
#(
    parameter int NIB_W = NRF_NIB_W,
    parameter int CELLS = NRF_BANKS * NRF_REGS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_we,
    input  logic [$clog2(CELLS)-1:0] wa_addr,
    input  logic [NIB_W-1:0]         wa_data,
    input  logic                     wb_we,
    input  logic [$clog2(CELLS)-1:0] wb_addr,
    input  logic [NIB_W-1:0]         wb_data,
    input  logic                     mem_we,
    input  logic [$clog2(CELLS)-1:0] mem_addr,
    input  logic [NIB_W-1:0]         mem_wdata,
    output logic [NIB_W-1:0]         cells_o [CELLS]
);
    localparam int AW = $clog2(CELLS);

    logic [NIB_W-1:0] cell_q [CELLS];

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        localparam logic [AW-1:0] ME = AW'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)                        cell_q[i] <= '0;
            else if (wa_we && wa_addr == ME)   cell_q[i] <= wa_data;
            else if (wb_we && wb_addr == ME)   cell_q[i] <= wb_data;
            else if (mem_we && mem_addr == ME) cell_q[i] <= mem_wdata;
        end
        assign cells_o[i] = cell_q[i];
    end

    p_reg_over_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_we && mem_we && wa_addr == mem_addr)
        |=> (cell_q[$past(wa_addr)] == $past(wa_data)));

    p_mem_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !(wa_we && wa_addr == mem_addr) && !(wb_we && wb_addr == mem_addr))
        |=> (cell_q[$past(mem_addr)] == $past(mem_wdata)));
endmodule

// File: rtl/nrf_read_mux.sv
module nrf_read_mux
    import nrf_pkg::*;
#(
    parameter int NIB_W = NRF_NIB_W,
    parameter int CELLS = NRF_BANKS * NRF_REGS
) (
    input  logic [NIB_W-1:0]         cells_i [CELLS],
    input  logic [1:0]               bank_i,
    input  logic [2:0]               nib_ridx,
    input  logic [1:0]               pair_rsel,
    input  logic                     pair_ralt,
    input  logic [$clog2(CELLS)-1:0] mem_addr,
    output logic [NIB_W-1:0]         nib_rdata,
    output logic [2*NIB_W-1:0]       pair_rdata,
    output logic [NIB_W-1:0]         mem_rdata
);
    logic [1:0] pbank;

    assign pbank      = bank_i ^ {1'b0, pair_ralt};
    assign nib_rdata  = cells_i[{bank_i, nib_ridx}];
    assign pair_rdata = {cells_i[{pbank, pair_rsel, 1'b0}],
                         cells_i[{pbank, pair_rsel, 1'b1}]};
    assign mem_rdata  = cells_i[mem_addr];
endmodule

// File: rtl/nreg_bank_file.sv
module nreg_bank_file
    import nrf_pkg::*;
#(
    parameter int   NIB_W      = NRF_NIB_W,
    parameter int   STK_DEPTH  = NRF_DEPTH,
    parameter logic ENTRY_FLAG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic [1:0]         sel_wdata,
    input  logic               flag_we,
    input  logic               flag_wdata,
    input  logic               irq_enter,
    input  logic               irq_return,
    input  logic [2:0]         nib_ridx,
    output logic [NIB_W-1:0]   nib_rdata,
    input  logic [1:0]         pair_rsel,
    input  logic               pair_ralt,
    output logic [2*NIB_W-1:0] pair_rdata,
    input  logic               reg_we,
    input  logic               reg_wide,
    input  logic [2:0]         reg_widx,
    input  logic [1:0]         reg_wpair,
    input  logic               reg_walt,
    input  logic [2*NIB_W-1:0] reg_wdata,
    input  logic               mem_we,
    input  logic [4:0]         mem_addr,
    input  logic [NIB_W-1:0]   mem_wdata,
    output logic [NIB_W-1:0]   mem_rdata,
    output logic               bank_en,
    output logic [1:0]         active_bank
);
    localparam int CELLS = NRF_BANKS * NRF_REGS;

    logic [1:0]       sel_q;
    logic [1:0]       wbank;
    logic             wa_we, wb_we;
    logic [4:0]       wa_addr, wb_addr;
    logic [NIB_W-1:0] wa_data, wb_data;
    logic [NIB_W-1:0] cells [CELLS];

    nrf_bank_ctrl #(.STK_DEPTH(STK_DEPTH), .ENTRY_FLAG(ENTRY_FLAG)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .irq_enter(irq_enter), .irq_return(irq_return),
        .flag_q(bank_en), .sel_q(sel_q), .bank_o(active_bank)
    );

    assign wbank = active_bank ^ {1'b0, reg_walt};

    always_comb begin
        wa_we   = reg_we;
        wb_we   = reg_we && reg_wide;
        wb_addr = {wbank, reg_wpair, 1'b1};
        wb_data = reg_wdata[NIB_W-1:0];
        if (reg_wide) begin
            wa_addr = {wbank, reg_wpair, 1'b0};
            wa_data = reg_wdata[2*NIB_W-1:NIB_W];
        end else begin
            wa_addr = {active_bank, reg_widx};
            wa_data = reg_wdata[NIB_W-1:0];
        end
    end

    nrf_cell_array #(.NIB_W(NIB_W), .CELLS(CELLS)) i_cells (
        .clk(clk), .rst_n(rst_n),
        .wa_we(wa_we), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cells_o(cells)
    );

    nrf_read_mux #(.NIB_W(NIB_W), .CELLS(CELLS)) i_rmux (
        .cells_i(cells), .bank_i(active_bank),
        .nib_ridx(nib_ridx), .pair_rsel(pair_rsel), .pair_ralt(pair_ralt),
        .mem_addr(mem_addr),
        .nib_rdata(nib_rdata), .pair_rdata(pair_rdata), .mem_rdata(mem_rdata)
    );

    p_flag_low_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_en && mem_addr[4:3] == 2'd0) |-> (nib_rdata == cells[{2'd0, nib_ridx}]));
endmodule

// File: tb/test_nreg_bank_file.sv
module test_nreg_bank_file;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_we = 0, flag_we = 0, flag_wdata = 0, irq_enter = 0, irq_return = 0;
    logic [1:0] sel_wdata = 0, pair_rsel = 0, reg_wpair = 0;
    logic [2:0] nib_ridx = 0, reg_widx = 0;
    logic       pair_ralt = 0, reg_we = 0, reg_wide = 0, reg_walt = 0, mem_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [4:0] mem_addr = 0;
    logic [3:0] mem_wdata = 0;
    logic [3:0] nib_rdata, mem_rdata;
    logic [7:0] pair_rdata;
    logic       bank_en;
    logic [1:0] active_bank;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nreg_bank_file i_nreg_bank_file (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_enter(irq_enter),
        .irq_return(irq_return), .nib_ridx(nib_ridx), .nib_rdata(nib_rdata),
        .pair_rsel(pair_rsel), .pair_ralt(pair_ralt), .pair_rdata(pair_rdata),
        .reg_we(reg_we), .reg_wide(reg_wide), .reg_widx(reg_widx),
        .reg_wpair(reg_wpair), .reg_walt(reg_walt), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .bank_en(bank_en), .active_bank(active_bank)
    );

    // {sel[1:0], en, pair[1:0], alt, data[7:0]}
    localparam logic [13:0] VEC [8] = '{
        {2'd3, 1'b1, 2'd0, 1'b0, 8'hA5},
        {2'd3, 1'b0, 2'd3, 1'b0, 8'h3C},
        {2'd2, 1'b1, 2'd1, 1'b1, 8'h7E},
        {2'd1, 1'b1, 2'd2, 1'b0, 8'h91},
        {2'd0, 1'b1, 2'd3, 1'b1, 8'hF0},
        {2'd2, 1'b1, 2'd2, 1'b0, 8'h4B},
        {2'd1, 1'b0, 2'd1, 1'b1, 8'hD2},
        {2'd0, 1'b0, 2'd0, 1'b0, 8'h66}
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_bank(logic [1:0] s, logic e);
        sel_we = 1; sel_wdata = s; flag_we = 1; flag_wdata = e;
        cyc();
        sel_we = 0; flag_we = 0;
    endtask

    task automatic pulse_irq(logic ent, logic ret);
        irq_enter = ent; irq_return = ret;
        cyc();
        irq_enter = 0; irq_return = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] eb;
        logic       err;
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        chk("R1 flag", {7'd0, bank_en}, 8'd0);
        chk("R1 bank", {6'd0, active_bank}, 8'd0);
        err = 0;
        for (int a = 0; a < 32; a++) begin
            mem_addr = 5'(a); #1;
            if (mem_rdata !== 4'd0) err = 1;
        end
        chk("R1 cells", {7'd0, err}, 8'd0);

        // vector table: R2 R3 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            set_bank(VEC[v][13:12], VEC[v][11]);
            eb = VEC[v][11] ? VEC[v][13:12] : 2'd0;
            chk("R2/R3 active_bank", {6'd0, active_bank}, {6'd0, eb});
            eb = eb ^ {1'b0, VEC[v][8]};
            reg_we = 1; reg_wide = 1; reg_wpair = VEC[v][10:9];
            reg_walt = VEC[v][8]; reg_wdata = VEC[v][7:0];
            cyc();
            reg_we = 0;
            pair_rsel = VEC[v][10:9]; pair_ralt = VEC[v][8];
            mem_addr = {eb, VEC[v][10:9], 1'b0}; #1;
            chk("R5/R6 pair read", pair_rdata, VEC[v][7:0]);
            chk("R7 alias high", {4'd0, mem_rdata}, {4'd0, VEC[v][7:4]});
            mem_addr = {eb, VEC[v][10:9], 1'b1}; #1;
            chk("R7 alias low", {4'd0, mem_rdata}, {4'd0, VEC[v][3:0]});
        end

        // R4 nibble write H in bank 2, read back by index and alias
        set_bank(2'd2, 1'b1);
        reg_we = 1; reg_wide = 0; reg_widx = 3'd6; reg_wdata = 8'h09;
        cyc();
        reg_we = 0; nib_ridx = 3'd6; mem_addr = 5'b10_110; #1;
        chk("R4 nibble H", {4'd0, nib_rdata}, 8'h09);
        chk("R4 alias H", {4'd0, mem_rdata}, 8'h09);

        // R7 memory write into bank 1 offset A, seen by register read
        set_bank(2'd1, 1'b1);
        mem_we = 1; mem_addr = 5'b01_001; mem_wdata = 4'hC;
        cyc();
        mem_we = 0; nib_ridx = 3'd1; #1;
        chk("R7 mem write to A", {4'd0, nib_rdata}, 8'h0C);

        // R8 conflict on bank 1 offset D
        reg_we = 1; reg_wide = 0; reg_widx = 3'd4; reg_wdata = 8'h03;
        mem_we = 1; mem_addr = 5'b01_100; mem_wdata = 4'hE;
        cyc();
        reg_we = 0; mem_we = 0; #1;
        chk("R8 register wins", {4'd0, mem_rdata}, 8'h03);

        // R2 flag low forces bank 0 even with select 3
        set_bank(2'd3, 1'b0);
        nib_ridx = 3'd0; mem_addr = 5'b00_000; #1;
        chk("R2 flag low bank", {6'd0, active_bank}, 8'd0);
        chk("R2 flag low read", {4'd0, nib_rdata}, {4'd0, mem_rdata});

        // R9/R10 nesting
        pulse_irq(1, 0);
        chk("R9 entry sets", {7'd0, bank_en}, 8'd1);
        flag_we = 1; flag_wdata = 0; cyc(); flag_we = 0;
        flag_we = 1; flag_wdata = 0; pulse_irq(1, 0); flag_we = 0;
        chk("R9 entry beats flag write", {7'd0, bank_en}, 8'd1);
        pulse_irq(1, 1);
        chk("R9 entry beats return", {7'd0, bank_en}, 8'd1);
        pulse_irq(0, 1);
        chk("R10 pop third", {7'd0, bank_en}, 8'd1);
        flag_we = 1; flag_wdata = 1; pulse_irq(0, 1); flag_we = 0;
        chk("R10 pop second beats write", {7'd0, bank_en}, 8'd0);
        pulse_irq(0, 1);
        chk("R10 pop first", {7'd0, bank_en}, 8'd0);
        pulse_irq(0, 1);
        chk("R12 empty return", {7'd0, bank_en}, 8'd0);

        // R11 overflow: saves 0,1,1,1,1,1,1,1 then a dropped save of 0
        for (int k = 0; k < 8; k++) pulse_irq(1, 0);
        flag_we = 1; flag_wdata = 0; cyc(); flag_we = 0;
        pulse_irq(1, 0);
        chk("R11 entry when full", {7'd0, bank_en}, 8'd1);
        pulse_irq(0, 1);
        chk("R11 dropped save", {7'd0, bank_en}, 8'd1);
        for (int k = 0; k < 6; k++) pulse_irq(0, 1);
        chk("R11 unwind", {7'd0, bank_en}, 8'd1);
        pulse_irq(0, 1);
        chk("R11 last pop", {7'd0, bank_en}, 8'd0);
        flag_we = 1; flag_wdata = 1; cyc(); flag_we = 0;
        pulse_irq(0, 1);
        chk("R12 empty keeps 1", {7'd0, bank_en}, 8'd1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule